// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a cycle-accurate model of a single-port synchronous SRAM with a common data bus and a four-beat burst address counter. On every rising clock edge it samples two address strobes (a processor strobe and a controller strobe), three chip enables, a burst-advance input and the write controls: a global write, a byte write enable and one select line per byte lane. From these it classifies the cycle as idle, deselect, begin read, begin write, continue burst or suspend burst. It then reads or writes its internal byte-lane memory.

Read data passes through a single output register and appears one clock after the cycle that addressed it. The bus drive-enable is formed without a clock from the output-enable input, the read-valid register and the write controls presented in the current cycle. Data goes in on `wr_data` and comes out on `rd_data`, and `bus_drive` tells the pad logic when to drive the shared bus.

Top module: `sbs_sram_ctrl`

## Requirements
- R1: After reset every memory word reads as zero and `bus_drive` is 0.
- R2: A begin-read cycle needs three things at the edge: an effective strobe, the chip selected and no active write controls. The read data for `addr` then appears on `rd_data` after that edge. `bus_drive` is 1 when `oe_n` is low.
- R3: `adsp_n` low is ignored while `ce1_n` is high. With `adsc_n` high, such a cycle neither loads a new address nor deselects the chip. An active burst goes on as a continue or suspend cycle.
- R4: A cycle started by the processor strobe (`adsp_n` low, `ce1_n` low) is a read whatever the write controls say. A write on the next edge happens if the write controls are active then and both strobes are high.
- R5: A controller-strobe start (`adsc_n` low, processor strobe not effective, chip selected, write controls active) writes `wr_data` to `addr` in that same cycle. `adsc_n` is ignored while the processor strobe is effective.
- R6: The byte mask works as follows. `gw_n` low writes all four lanes. With `gw_n` high and `bwe_n` low, a lane is written when its `bw_n` bit is 0, and bit i selects bits 8i+7..8i. With `gw_n` and `bwe_n` both high, nothing is written. Lanes that are not selected keep their contents.
- R7: `bus_drive` is 0 in any cycle whose write controls select at least one lane, and whenever `oe_n` is high. `oe_n` acts without a clock.
- R8: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. An effective strobe with any other combination is a deselect cycle. After it, `bus_drive` stays 0, including during later cycles with both strobes high.
- R9: With both strobes high during an active burst, `adv_n` low moves to the next of four beats. The beats use the two low address bits. With `burst_linear`=1 the low bits are start+k mod 4. With `burst_linear`=0 they are start XOR k. The upper address bits stay the same.
- R10: With both strobes high during an active burst, `adv_n` high reuses the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 10 | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Byte lane selects, active low |
| burst_linear | input | 1 | 1 = linear beat order, 0 = interleaved |
| oe_n | input | 1 | Output enable, active low, unclocked |
| wr_data | input | 32 | Data from the bus |
| rd_data | output | 32 | Registered read data |
| bus_drive | output | 1 | Drive-enable for the bus |

## Verification
The assertions assume that every input is stable around the rising edge. The address checks also assume that `burst_linear` does not change between the cycles they compare, so that property is gated on `$stable(burst_linear)`. The bench drives all inputs on the falling edge and keeps the address inside a 64-word window so that reads often return earlier writes. It weights the strobes, enables and write controls so that deselects, strobe conflicts and long bursts all come up, and it changes `burst_linear` only now and then.

// File: rtl/sbs_pkg.sv
// Package: shared cycle classification for the burst SRAM controller.
// Assumes: one cycle type is chosen per rising clock edge.
package sbs_pkg;

    typedef enum logic [2:0] {
        CY_IDLE     = 3'd0,
        CY_DESEL    = 3'd1,
        CY_RD_BEGIN = 3'd2,
        CY_WR_BEGIN = 3'd3,
        CY_CONT     = 3'd4,
        CY_SUSP     = 3'd5
    } sbs_cycle_e;

endpackage

// File: rtl/sbs_cycle_decode.sv
// Module: sbs_cycle_decode
// Turns the strobes, chip enables, advance and write controls into one cycle
// type, plus the load, step, byte-write and read-enable controls.
// Assumes: all inputs are synchronous and stable at the rising edge.
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          active_q,
    output sbs_cycle_e    cyc,
    output logic          load,
    output logic          clear,
    output logic          step,
    output logic          wr_req,
    output logic [NB-1:0] mem_be,
    output logic          do_read
);

    logic          sel;
    logic          adsp_go;
    logic          adsc_go;
    logic [NB-1:0] mask_raw;

    // Lane mask requested by the write controls; global write wins.
    always_comb begin
        if (!gw_n)       mask_raw = '1;
        else if (!bwe_n) mask_raw = ~bw_n;
        else             mask_raw = '0;
    end

    // Strobe qualification and chip-select decode.
    always_comb begin
        sel     = !ce1_n && ce2 && !ce3_n;
        adsp_go = !adsp_n && !ce1_n;
        adsc_go = !adsc_n && !adsp_go;
        wr_req  = |mask_raw;
    end

    // Cycle classification.
    always_comb begin
        if (adsp_go || adsc_go) begin
            if (!sel)                     cyc = CY_DESEL;
            else if (adsp_go || !wr_req)  cyc = CY_RD_BEGIN;
            else                          cyc = CY_WR_BEGIN;
        end else if (!active_q) begin
            cyc = CY_IDLE;
        end else if (adv_n) begin
            cyc = CY_SUSP;
        end else begin
            cyc = CY_CONT;
        end
    end

    // Controls derived from the cycle type.
    always_comb begin
        load    = (cyc == CY_RD_BEGIN) || (cyc == CY_WR_BEGIN);
        clear   = (cyc == CY_DESEL);
        step    = (cyc == CY_CONT);
        mem_be  = '0;
        do_read = 1'b0;
        case (cyc)
            CY_WR_BEGIN: mem_be = mask_raw;
            CY_RD_BEGIN: do_read = 1'b1;
            CY_CONT, CY_SUSP: begin
                mem_be  = mask_raw;
                do_read = !wr_req;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sbs_burst_addr.sv
// Module: sbs_burst_addr
// Holds the burst base address and beat counter, and forms the address used
// in the current cycle in linear or interleaved order.
// Assumes: load and step are never both high.
module sbs_burst_addr #(
    parameter int AW = 10,
    parameter int OW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] acc_addr
);

    logic [AW-OW-1:0] hi_q;
    logic [OW-1:0]    a0_q;
    logic [OW-1:0]    k_q;
    logic [OW-1:0]    k_use;
    logic [OW-1:0]    low;

    // Beat index used in this cycle and its low address bits.
    always_comb begin
        k_use = step ? OW'(k_q + 1'b1) : k_q;
        low   = linear ? OW'(a0_q + k_use) : (a0_q ^ k_use);
        acc_addr = load ? addr_in : {hi_q, low};
    end

    // Base and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            a0_q <= '0;
            k_q  <= '0;
        end else if (load) begin
            hi_q <= addr_in[AW-1:OW];
            a0_q <= addr_in[OW-1:0];
            k_q  <= '0;
        end else if (step) begin
            k_q  <= k_use;
        end
    end

endmodule

// File: rtl/sbs_mem_array.sv
// Module: sbs_mem_array
// Byte-lane memory with a lane write mask and a registered read port.
// Assumes: read and write are not requested in the same cycle; contents
// are cleared by reset.
module sbs_mem_array #(
    parameter int AW = 10,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic [NB-1:0]  be,
    input  logic [NB*LW-1:0] din,
    input  logic           rd_en,
    output logic [NB*LW-1:0] dout
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] arr [DEPTH];
        logic [LW-1:0] rd_q;

        // Lane storage: clear on reset, masked write otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
            end else if (be[g]) begin
                arr[addr] <= din[g*LW +: LW];
            end
        end

        // Lane read register.
        always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= arr[addr];
        end

        assign dout[g*LW +: LW] = rd_q;
    end

endmodule

// File: rtl/sbs_sram_ctrl.sv
// Module: sbs_sram_ctrl (top)
// Synchronous burst SRAM model: cycle decode, burst address, byte-lane array,
// registered read data and an unclocked bus drive-enable.
// Assumes: the caller ties the bus together externally from rd_data,
// wr_data and bus_drive.
module sbs_sram_ctrl
    import sbs_pkg::*;
#(
    parameter int AW = 10,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [NB-1:0]    bw_n,
    input  logic             burst_linear,
    input  logic             oe_n,
    input  logic [NB*LW-1:0] wr_data,
    output logic [NB*LW-1:0] rd_data,
    output logic             bus_drive
);

    localparam int OW = 2;

    sbs_cycle_e    cyc;
    logic          load, clear, step, wr_req, do_read;
    logic [NB-1:0] mem_be;
    logic [AW-1:0] acc_addr;
    logic          active_q;
    logic          rd_valid_q;

    sbs_cycle_decode #(.NB(NB)) i_dec (
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .active_q(active_q), .cyc(cyc), .load(load), .clear(clear),
        .step(step), .wr_req(wr_req), .mem_be(mem_be), .do_read(do_read)
    );

    sbs_burst_addr #(.AW(AW), .OW(OW)) i_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .linear(burst_linear), .addr_in(addr), .acc_addr(acc_addr)
    );

    sbs_mem_array #(.AW(AW), .NB(NB), .LW(LW)) i_mem (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr), .be(mem_be),
        .din(wr_data), .rd_en(do_read), .dout(rd_data)
    );

    // Burst-active flag: set by a begin cycle, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)     active_q <= 1'b0;
        else if (load)  active_q <= 1'b1;
        else if (clear) active_q <= 1'b0;
    end

    // Read-valid flag for the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= do_read;
    end

    // Unclocked drive-enable: output enable, valid data, no write this cycle.
    assign bus_drive = !oe_n && rd_valid_q && !wr_req;

    // R3
    ce1_blocks_adsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && adsc_n) |-> !load);

    // R4 R5
    adsp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (mem_be == '0));

    // R7
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n || oe_n) |-> !bus_drive);

    // R8
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !bus_drive);

    // R9
    cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CY_CONT && $stable(burst_linear)) |->
        (acc_addr[AW-1:OW] == $past(acc_addr[AW-1:OW]) && acc_addr != $past(acc_addr)));

    // R10
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CY_SUSP && $stable(burst_linear)) |-> (acc_addr == $past(acc_addr)));

endmodule

// File: tb/test_sbs_sram_ctrl.sv
module test_sbs_sram_ctrl;

    localparam int CLK_P = 10;
    localparam int AW = 10;
    localparam int NB = 4;
    localparam int DW = 32;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce1_n = 0, ce2 = 1, ce3_n = 0;
    logic gw_n = 1, bwe_n = 1, burst_linear = 1, oe_n = 0;
    logic [NB-1:0] bw_n = '1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic bus_drive;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [DW-1:0] m_mem [1<<AW];
    bit            m_active, m_valid;
    logic [AW-3:0] m_hi;
    logic [1:0]    m_a0, m_k;
    logic [DW-1:0] m_data;

    always #(CLK_P/2) clk = ~clk;

    sbs_sram_ctrl i_sbs_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .burst_linear(burst_linear), .oe_n(oe_n),
        .wr_data(wr_data), .rd_data(rd_data), .bus_drive(bus_drive)
    );

    function automatic logic [NB-1:0] lane_mask(logic g, logic b, logic [NB-1:0] s);
        if (!g) return '1;
        if (!b) return ~s;
        return '0;
    endfunction

    function automatic logic [1:0] beat_low(logic [1:0] a0, logic [1:0] k, logic lin);
        return lin ? 2'(a0 + k) : (a0 ^ k);
    endfunction

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference behaviour at a rising edge, from the requirements.
    task automatic model_edge();
        logic [NB-1:0] m = lane_mask(gw_n, bwe_n, bw_n);
        bit sel = !ce1_n && ce2 && !ce3_n;
        bit pgo = !adsp_n && !ce1_n;
        bit cgo = !adsc_n && !pgo;
        logic [AW-1:0] a;
        bit rd = 0, wr = 0;
        if (pgo || cgo) begin
            if (!sel) m_active = 0;
            else begin
                m_active = 1; m_hi = addr[AW-1:2]; m_a0 = addr[1:0]; m_k = 0;
                a = addr;
                if (pgo || m == 0) rd = 1; else wr = 1;
            end
        end else if (m_active) begin
            if (!adv_n) m_k = m_k + 2'd1;
            a = {m_hi, beat_low(m_a0, m_k, burst_linear)};
            if (m == 0) rd = 1; else wr = 1;
        end
        if (wr) for (int i = 0; i < NB; i++)
            if (m[i]) m_mem[a][i*8 +: 8] = wr_data[i*8 +: 8];
        if (rd) m_data = m_mem[a];
        m_valid = rd;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        #(CLK_P/4);
        chk({tag, " drive"}, {31'd0, bus_drive},
            {31'd0, m_valid && !oe_n && lane_mask(gw_n, bwe_n, bw_n) == 0});
        if (m_valid) chk({tag, " data"}, rd_data, m_data);
        @(negedge clk);
    endtask

    task automatic idle_in();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0;
    endtask

    task automatic c_write(logic [AW-1:0] a, logic [DW-1:0] d);
        idle_in(); adsc_n = 0; addr = a; gw_n = 0; wr_data = d; step("R5 write");
    endtask

    task automatic c_read(logic [AW-1:0] a);
        idle_in(); adsc_n = 0; addr = a; step("R2 read");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
        m_active = 0; m_valid = 0; m_data = '0; m_hi = '0; m_a0 = '0; m_k = '0;
        repeat (3) @(negedge clk);
        chk("R1 drive after reset", {31'd0, bus_drive}, 32'd0);
        rst_n = 1;

        // R1: cleared memory reads zero
        c_read(10'd5);
        chk("R1 zero word", rd_data, 32'h0);
        chk("R2 drive on read", {31'd0, bus_drive}, 32'd1);

        // R5 write via controller strobe, R2 read via processor strobe
        c_write(10'd5, 32'hA5A5_0001);
        idle_in(); adsp_n = 0; addr = 10'd5; step("R2 adsp read");
        chk("R2 adsp data", rd_data, 32'hA5A5_0001);

        // R4: write controls ignored in the processor-strobe cycle, used next edge
        idle_in(); adsp_n = 0; addr = 10'd8; gw_n = 0; wr_data = 32'hDEAD_BEEF;
        step("R4 start");
        chk("R7 hiz on write", {31'd0, bus_drive}, 32'd0);
        idle_in(); gw_n = 0; wr_data = 32'h1234_5678; step("R4 late write");
        c_read(10'd8);
        chk("R4 written", rd_data, 32'h1234_5678);

        // R6: byte lanes 0 and 2 only
        idle_in(); adsc_n = 0; addr = 10'd8; bwe_n = 0; bw_n = 4'b1010;
        wr_data = 32'hAABB_CCDD; step("R6 bytes");
        c_read(10'd8);
        chk("R6 partial", rd_data, 32'h12BB_56DD);
        idle_in(); adsc_n = 0; addr = 10'd8; wr_data = 32'h0BAD_0BAD; step("R6 no write");
        chk("R6 none", rd_data, 32'h12BB_56DD);
        idle_in(); adsc_n = 0; addr = 10'd8; gw_n = 0; bwe_n = 0; bw_n = 4'b1110;
        wr_data = 32'h7777_8888; step("R6 global");
        c_read(10'd8);
        chk("R6 global priority", rd_data, 32'h7777_8888);

        // R5: controller strobe ignored while processor strobe is effective
        idle_in(); adsp_n = 0; adsc_n = 0; addr = 10'd5; gw_n = 0;
        wr_data = 32'hFFFF_FFFF; step("R5 conflict");
        c_read(10'd5);
        chk("R5 unchanged", rd_data, 32'hA5A5_0001);

        // R3: processor strobe ignored with ce1_n high
        c_write(10'd20, 32'h0000_0020);
        c_write(10'd40, 32'h0000_0040);
        c_read(10'd20);
        idle_in(); adsp_n = 0; ce1_n = 1; addr = 10'd40; step("R3 ignored");
        chk("R3 still 20", rd_data, 32'h0000_0020);
        chk("R3 drive kept", {31'd0, bus_drive}, 32'd1);

        // R8: deselect, then continue stays hi-z
        idle_in(); adsc_n = 0; ce2 = 0; addr = 10'd5; step("R8 desel");
        chk("R8 hiz", {31'd0, bus_drive}, 32'd0);
        idle_in(); adv_n = 0; step("R8 cont");
        chk("R8 hiz cont", {31'd0, bus_drive}, 32'd0);
        idle_in(); adsp_n = 0; ce3_n = 1; addr = 10'd5; step("R8 desel ce3");
        chk("R8 hiz ce3", {31'd0, bus_drive}, 32'd0);

        // R9: linear and interleaved beats from low bits 01
        for (int i = 0; i < 4; i++) c_write(10'(16 + i), 32'h100 + i);
        burst_linear = 1;
        c_read(10'd17);
        idle_in(); adv_n = 0; step("R9 lin"); chk("R9 lin b1", rd_data, 32'h102);
        step("R9 lin"); chk("R9 lin b2", rd_data, 32'h103);
        step("R9 lin"); chk("R9 lin wrap", rd_data, 32'h100);
        burst_linear = 0;
        c_read(10'd17);
        idle_in(); adv_n = 0; step("R9 il"); chk("R9 il b1", rd_data, 32'h100);
        step("R9 il"); chk("R9 il b2", rd_data, 32'h103);
        step("R9 il"); chk("R9 il b3", rd_data, 32'h102);

        // R10: suspend reuses the address
        burst_linear = 1;
        c_read(10'd18);
        idle_in(); step("R10 susp"); chk("R10 same", rd_data, 32'h102);
        idle_in(); adv_n = 0; step("R10 resume"); chk("R10 next", rd_data, 32'h103);

        // R7: output enable acts without a clock
        idle_in(); oe_n = 1; #1;
        chk("R7 oe high", {31'd0, bus_drive}, 32'd0);
        oe_n = 0; #1;
        chk("R7 oe low", {31'd0, bus_drive}, 32'd1);

        // Random mix
        void'($urandom(32'd7));
        for (int n = 0; n < 4000; n++) begin
            adsp_n = ($urandom % 100) >= 15;
            adsc_n = ($urandom % 100) >= 15;
            ce1_n  = ($urandom % 100) < 10;
            ce2    = ($urandom % 100) >= 5;
            ce3_n  = ($urandom % 100) < 5;
            gw_n   = ($urandom % 100) >= 10;
            bwe_n  = ($urandom % 100) >= 25;
            bw_n   = 4'($urandom);
            adv_n  = ($urandom % 100) >= 60;
            oe_n   = ($urandom % 100) >= 85;
            addr   = 10'($urandom % 64);
            wr_data = $urandom;
            if ($urandom % 200 == 0) burst_linear = ~burst_linear;
            step("R2 R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule